// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block works out how a small 32-bit processor's special registers change when control moves to a handler. Five request lines mark the cause: hardware exception, MMU fault, external interrupt, software break or hardware break. The core also supplies the current program counter and branch target. It gives the instruction-state flags: the instruction sits in a branch delay slot, an immediate prefix is pending, and the branch had an immediate prefix. For an MMU fault it adds the fault kind, the access type and the faulting address.

On the clock edge after a request is accepted, the block presents all of its results together. These are the handler PC, a link-register write (index and value), and new values for the machine status (MSR), exception status (ESR), exception address (EAR) and branch target (BTR) registers. A one-cycle `done` pulse marks them. A matching `state_clr` pulse tells the core to drop its delay-slot flag, its immediate-prefix flag and its load reservation. Between entries every output holds its last value.

The core feeds back the live MSR, ESR, EAR and BTR on `*_in` and commits the `*_out` values while `done` is high. Bit positions used throughout: MSR IE=1, BIP=3, EIP=9, UM=11, UMS=12, VM=13, VMS=14; ESR store flag=10, delay-slot flag=12, fault code in bits 4:0.

Top module: `exc_entry_ctrl`

## Requirements
- R1: When several requests are high in one cycle, only one is taken, in this order: hardware break, MMU fault, hardware exception, software break, interrupt. A request that is refused does not block a lower one.
- R2: A hardware exception writes PC+4 to register 17, jumps to 0x20 and sets MSR bit 9. It is refused (no `done`, outputs unchanged) while `exc_en` is low.
- R3: An MMU fault writes a rewound PC to register 17 and jumps to 0x20. The rewind is 8 in a delay slot after a prefixed branch, 4 in any other delay slot, 4 with only a prefix pending, and 0 otherwise. It also sets MSR bit 9.
- R4: An MMU fault sets ESR to the fault code in bits 4:0 and clears every other bit except 10 and 12. The code is 16 for a data protection fault, 17 for a fetch protection fault, 18 for a data miss and 19 for a fetch miss. Bit 10 is 1 for a store. EAR takes the faulting address.
- R5: For hardware exceptions and MMU faults, ESR bit 12 equals the delay-slot flag. BTR takes the branch target when that flag is set and keeps its input value otherwise. On other entries ESR, EAR and BTR pass their inputs through unchanged.
- R6: Every entry copies MSR bit 13 to bit 14 and bit 11 to bit 12, then clears bits 13 and 11. Bits not named in R2, R3, R7 and R8 pass through.
- R7: An interrupt is accepted only with MSR bit 1 set, bits 9 and 3 clear and no delay slot. It clears bit 1, writes PC to register 14 and jumps to 0x10. Otherwise it is refused.
- R8: A hardware break writes PC to register 16, sets MSR bit 3 and jumps to 0x18. A software break sets bit 3, jumps to the branch target and writes no link register.
- R9: Results appear on the first clock edge after the request. `done`, `state_clr` and (for classes with a link) `link_we` pulse for exactly that cycle. All outputs hold their values when nothing is accepted.
- R10: An MMU fault that wins while an earlier MMU-fault entry has not been released by `fault_clear` raises `fatal_err` for one cycle and is not entered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_en | input | 1 | Hardware exception support enabled |
| req_hw_exc | input | 1 | Hardware exception request |
| req_mmu | input | 1 | MMU fault request |
| req_irq | input | 1 | External interrupt request |
| req_sw_brk | input | 1 | Software break request |
| req_hw_brk | input | 1 | Hardware break request |
| fault_clear | input | 1 | Handler has finished with the pending MMU fault |
| pc_in | input | 32 | Current program counter |
| btarget_in | input | 32 | Current branch target |
| in_dslot | input | 1 | Instruction sits in a delay slot |
| imm_pend | input | 1 | Immediate prefix pending |
| br_had_imm | input | 1 | Branch owning the delay slot had a prefix |
| flt_miss | input | 1 | MMU fault kind: 1 miss, 0 protection |
| flt_acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| flt_addr | input | 32 | Faulting address |
| msr_in | input | 32 | Live MSR |
| esr_in | input | 32 | Live ESR |
| ear_in | input | 32 | Live EAR |
| btr_in | input | 32 | Live BTR |
| done | output | 1 | Entry results valid this cycle |
| state_clr | output | 1 | Clear delay-slot, prefix and reservation state |
| fatal_err | output | 1 | Recursive MMU fault detected |
| pc_out | output | 32 | Handler PC |
| link_we | output | 1 | Link register write enable |
| link_idx | output | 5 | Link register index |
| link_val | output | 32 | Link register value |
| msr_out | output | 32 | New MSR |
| esr_out | output | 32 | New ESR |
| ear_out | output | 32 | New EAR |
| btr_out | output | 32 | New BTR |

## Verification
Each request class is applied alone against every combination of the three instruction-state flags and the five MSR control bits. MMU faults are also crossed with both fault kinds and all three access types. This separates the rewind amounts, the four fault codes and the store flag, and shows that interrupt acceptance depends on each gating bit. Mixed requests show the priority order and that a refused hardware exception or interrupt lets a lower request through. A back-to-back pair of MMU faults without release shows that the recursive-fault error fires and the outputs stay unchanged.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int SRW = 32;

  localparam int MSR_IE  = 1;
  localparam int MSR_BIP = 3;
  localparam int MSR_EIP = 9;
  localparam int MSR_UM  = 11;
  localparam int MSR_UMS = 12;
  localparam int MSR_VM  = 13;
  localparam int MSR_VMS = 14;

  localparam int ESR_STORE = 10;
  localparam int ESR_DS    = 12;

  localparam logic [1:0] ACC_LOAD  = 2'd0;
  localparam logic [1:0] ACC_STORE = 2'd1;
  localparam logic [1:0] ACC_FETCH = 2'd2;

  typedef enum logic [2:0] {
    EV_NONE  = 3'd0,
    EV_HWEXC = 3'd1,
    EV_MMU   = 3'd2,
    EV_IRQ   = 3'd3,
    EV_SWBRK = 3'd4,
    EV_HWBRK = 3'd5
  } ev_e;

  // Push the two mode bits into their shadow positions and drop them.
  function automatic logic [SRW-1:0] stack_modes(input logic [SRW-1:0] m);
    logic [SRW-1:0] r;
    r          = m;
    r[MSR_VMS] = m[MSR_VM];
    r[MSR_UMS] = m[MSR_UM];
    r[MSR_VM]  = 1'b0;
    r[MSR_UM]  = 1'b0;
    return r;
  endfunction

  // Fault code: base 16, +2 for a miss, +1 for an instruction fetch.
  function automatic logic [4:0] fault_code(input logic miss, input logic [1:0] acc);
    return 5'd16 + {3'b000, miss, 1'b0} + {4'b0000, (acc == ACC_FETCH)};
  endfunction

  function automatic logic is_exc(input ev_e e);
    return (e == EV_HWEXC) || (e == EV_MMU);
  endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_entry_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic exc_en,
  input  logic req_hw_exc,
  input  logic req_mmu,
  input  logic req_irq,
  input  logic req_sw_brk,
  input  logic req_hw_brk,
  input  logic irq_ie,
  input  logic irq_eip,
  input  logic irq_bip,
  input  logic in_dslot,
  output ev_e  ev
);

  logic irq_ok;
  logic hwexc_ok;

  assign irq_ok   = irq_ie & ~irq_eip & ~irq_bip & ~in_dslot;
  assign hwexc_ok = req_hw_exc & exc_en;

  always_comb begin
    if (req_hw_brk)            ev = EV_HWBRK;
    else if (req_mmu)          ev = EV_MMU;
    else if (hwexc_ok)         ev = EV_HWEXC;
    else if (req_sw_brk)       ev = EV_SWBRK;
    else if (req_irq && irq_ok) ev = EV_IRQ;
    else                       ev = EV_NONE;
  end

  a_r1_hwbrk_wins: assert property (@(posedge clk) disable iff (!rst_n)
    req_hw_brk |-> (ev == EV_HWBRK));

  a_r7_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_IRQ) |-> (req_irq && irq_ie && !irq_eip && !irq_bip && !in_dslot));

  a_r2_hwexc_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !exc_en |-> (ev != EV_HWEXC));

endmodule

// File: rtl/exc_target_calc.sv
module exc_target_calc
  import exc_entry_pkg::*;
#(
  parameter int AW  = 32,
  parameter int RIW = 5,
  parameter logic [AW-1:0]  VEC_EXC   = 'h20,
  parameter logic [AW-1:0]  VEC_IRQ   = 'h10,
  parameter logic [AW-1:0]  VEC_HWBRK = 'h18,
  parameter logic [RIW-1:0] LNK_EXC   = 'd17,
  parameter logic [RIW-1:0] LNK_IRQ   = 'd14,
  parameter logic [RIW-1:0] LNK_BRK   = 'd16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  ev_e            ev,
  input  logic [AW-1:0]  pc_in,
  input  logic [AW-1:0]  btarget_in,
  input  logic           in_dslot,
  input  logic           imm_pend,
  input  logic           br_had_imm,
  output logic [AW-1:0]  nxt_pc,
  output logic           lwe,
  output logic [RIW-1:0] lidx,
  output logic [AW-1:0]  lval
);

  // Number of instruction words to step back for a re-executed fault.
  function automatic logic [1:0] rewind_words(input logic ds, input logic imm, input logic bimm);
    if (ds)       return bimm ? 2'd2 : 2'd1;
    else if (imm) return 2'd1;
    else          return 2'd0;
  endfunction

  logic [AW-1:0] mmu_link;
  logic [AW-1:0] seq_link;

  assign mmu_link = pc_in - {{(AW-4){1'b0}}, rewind_words(in_dslot, imm_pend, br_had_imm), 2'b00};
  assign seq_link = pc_in + {{(AW-3){1'b0}}, 3'd4};

  always_comb begin
    nxt_pc = pc_in;
    lwe    = 1'b0;
    lidx   = '0;
    lval   = '0;
    case (ev)
      EV_HWEXC: begin nxt_pc = VEC_EXC;   lwe = 1'b1; lidx = LNK_EXC; lval = seq_link; end
      EV_MMU:   begin nxt_pc = VEC_EXC;   lwe = 1'b1; lidx = LNK_EXC; lval = mmu_link; end
      EV_IRQ:   begin nxt_pc = VEC_IRQ;   lwe = 1'b1; lidx = LNK_IRQ; lval = pc_in;    end
      EV_HWBRK: begin nxt_pc = VEC_HWBRK; lwe = 1'b1; lidx = LNK_BRK; lval = pc_in;    end
      EV_SWBRK: begin nxt_pc = btarget_in; end
      default: ;
    endcase
  end

  a_r3_rewind_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_MMU) |-> ((pc_in - lval) <= AW'(8)));

  a_r8_swbrk_nolink: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_SWBRK) |-> !lwe);

endmodule

// File: rtl/exc_sreg_update.sv
module exc_sreg_update
  import exc_entry_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  ev_e            ev,
  input  logic [SRW-1:0] msr_in,
  input  logic [SRW-1:0] esr_in,
  input  logic [AW-1:0]  ear_in,
  input  logic [AW-1:0]  btr_in,
  input  logic [AW-1:0]  btarget_in,
  input  logic           in_dslot,
  input  logic           flt_miss,
  input  logic [1:0]     flt_acc,
  input  logic [AW-1:0]  flt_addr,
  output logic [SRW-1:0] msr_n,
  output logic [SRW-1:0] esr_n,
  output logic [AW-1:0]  ear_n,
  output logic [AW-1:0]  btr_n
);

  always_comb begin
    msr_n = stack_modes(msr_in);
    esr_n = esr_in;
    ear_n = ear_in;
    btr_n = btr_in;
    case (ev)
      EV_HWEXC: msr_n[MSR_EIP] = 1'b1;
      EV_MMU: begin
        msr_n[MSR_EIP]   = 1'b1;
        esr_n            = '0;
        esr_n[4:0]       = fault_code(flt_miss, flt_acc);
        esr_n[ESR_STORE] = (flt_acc == ACC_STORE);
        ear_n            = flt_addr;
      end
      EV_IRQ:             msr_n[MSR_IE]  = 1'b0;
      EV_SWBRK, EV_HWBRK: msr_n[MSR_BIP] = 1'b1;
      default: ;
    endcase
    if (is_exc(ev)) begin
      esr_n[ESR_DS] = in_dslot;
      if (in_dslot) btr_n = btarget_in;
    end
  end

  a_r4_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_MMU) |-> (esr_n[4:0] >= 5'd16 && esr_n[4:0] <= 5'd19));

  a_r5_btr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_dslot || !is_exc(ev)) |-> (btr_n == btr_in));

  a_r6_modes_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != EV_NONE) |-> (!msr_n[MSR_VM] && !msr_n[MSR_UM]));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
#(
  parameter int AW  = 32,
  parameter int RIW = 5,
  parameter logic [AW-1:0] VEC_EXC   = 'h20,
  parameter logic [AW-1:0] VEC_IRQ   = 'h10,
  parameter logic [AW-1:0] VEC_HWBRK = 'h18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            exc_en,
  input  logic            req_hw_exc,
  input  logic            req_mmu,
  input  logic            req_irq,
  input  logic            req_sw_brk,
  input  logic            req_hw_brk,
  input  logic            fault_clear,
  input  logic [AW-1:0]   pc_in,
  input  logic [AW-1:0]   btarget_in,
  input  logic            in_dslot,
  input  logic            imm_pend,
  input  logic            br_had_imm,
  input  logic            flt_miss,
  input  logic [1:0]      flt_acc,
  input  logic [AW-1:0]   flt_addr,
  input  logic [31:0]     msr_in,
  input  logic [31:0]     esr_in,
  input  logic [AW-1:0]   ear_in,
  input  logic [AW-1:0]   btr_in,
  output logic            done,
  output logic            state_clr,
  output logic            fatal_err,
  output logic [AW-1:0]   pc_out,
  output logic            link_we,
  output logic [RIW-1:0]  link_idx,
  output logic [AW-1:0]   link_val,
  output logic [31:0]     msr_out,
  output logic [31:0]     esr_out,
  output logic [AW-1:0]   ear_out,
  output logic [AW-1:0]   btr_out
);

  ev_e            ev;
  logic [AW-1:0]  nxt_pc;
  logic           lwe;
  logic [RIW-1:0] lidx;
  logic [AW-1:0]  lval;
  logic [SRW-1:0] msr_n, esr_n;
  logic [AW-1:0]  ear_n, btr_n;
  logic           mmu_active;
  logic           recursive_hit;
  logic           enter;

  exc_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .exc_en(exc_en),
    .req_hw_exc(req_hw_exc), .req_mmu(req_mmu), .req_irq(req_irq),
    .req_sw_brk(req_sw_brk), .req_hw_brk(req_hw_brk),
    .irq_ie(msr_in[MSR_IE]), .irq_eip(msr_in[MSR_EIP]), .irq_bip(msr_in[MSR_BIP]),
    .in_dslot(in_dslot), .ev(ev)
  );

  exc_target_calc #(
    .AW(AW), .RIW(RIW), .VEC_EXC(VEC_EXC), .VEC_IRQ(VEC_IRQ), .VEC_HWBRK(VEC_HWBRK)
  ) u_tgt (
    .clk(clk), .rst_n(rst_n), .ev(ev), .pc_in(pc_in), .btarget_in(btarget_in),
    .in_dslot(in_dslot), .imm_pend(imm_pend), .br_had_imm(br_had_imm),
    .nxt_pc(nxt_pc), .lwe(lwe), .lidx(lidx), .lval(lval)
  );

  exc_sreg_update #(.AW(AW)) u_sreg (
    .clk(clk), .rst_n(rst_n), .ev(ev), .msr_in(msr_in), .esr_in(esr_in),
    .ear_in(ear_in), .btr_in(btr_in), .btarget_in(btarget_in), .in_dslot(in_dslot),
    .flt_miss(flt_miss), .flt_acc(flt_acc), .flt_addr(flt_addr),
    .msr_n(msr_n), .esr_n(esr_n), .ear_n(ear_n), .btr_n(btr_n)
  );

  // Named events for the assertions below.
  assign recursive_hit = (ev == EV_MMU) && mmu_active;
  assign enter         = (ev != EV_NONE) && !recursive_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done       <= 1'b0;
      state_clr  <= 1'b0;
      fatal_err  <= 1'b0;
      link_we    <= 1'b0;
      mmu_active <= 1'b0;
      pc_out     <= '0;
      link_idx   <= '0;
      link_val   <= '0;
      msr_out    <= '0;
      esr_out    <= '0;
      ear_out    <= '0;
      btr_out    <= '0;
    end else begin
      done      <= enter;
      state_clr <= enter;
      fatal_err <= recursive_hit;
      link_we   <= enter && lwe;
      if (enter && ev == EV_MMU) mmu_active <= 1'b1;
      else if (fault_clear)      mmu_active <= 1'b0;
      if (enter) begin
        pc_out  <= nxt_pc;
        msr_out <= msr_n;
        esr_out <= esr_n;
        ear_out <= ear_n;
        btr_out <= btr_n;
        if (lwe) begin
          link_idx <= lidx;
          link_val <= lval;
        end
      end
    end
  end

  a_r6_shadow_copy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (msr_out[MSR_VMS] == $past(msr_in[MSR_VM]) &&
              msr_out[MSR_UMS] == $past(msr_in[MSR_UM])));

  a_r10_recursive: assert property (@(posedge clk) disable iff (!rst_n)
    recursive_hit |=> (fatal_err && !done));

  a_r9_hold_pc: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (pc_out == $past(pc_out)));

  a_r9_clear_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (done != state_clr) |-> 1'b0);

endmodule

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        exc_en, req_hw_exc, req_mmu, req_irq, req_sw_brk, req_hw_brk, fault_clear;
  logic [31:0] pc_in, btarget_in, flt_addr, msr_in, esr_in, ear_in, btr_in;
  logic        in_dslot, imm_pend, br_had_imm, flt_miss;
  logic [1:0]  flt_acc;
  logic        done, state_clr, fatal_err, link_we;
  logic [31:0] pc_out, link_val, msr_out, esr_out, ear_out, btr_out;
  logic [4:0]  link_idx;

  exc_entry_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .exc_en(exc_en),
    .req_hw_exc(req_hw_exc), .req_mmu(req_mmu), .req_irq(req_irq),
    .req_sw_brk(req_sw_brk), .req_hw_brk(req_hw_brk), .fault_clear(fault_clear),
    .pc_in(pc_in), .btarget_in(btarget_in), .in_dslot(in_dslot), .imm_pend(imm_pend),
    .br_had_imm(br_had_imm), .flt_miss(flt_miss), .flt_acc(flt_acc), .flt_addr(flt_addr),
    .msr_in(msr_in), .esr_in(esr_in), .ear_in(ear_in), .btr_in(btr_in),
    .done(done), .state_clr(state_clr), .fatal_err(fatal_err), .pc_out(pc_out),
    .link_we(link_we), .link_idx(link_idx), .link_val(link_val),
    .msr_out(msr_out), .esr_out(esr_out), .ear_out(ear_out), .btr_out(btr_out)
  );

  int nchk = 0;
  int nfail = 0;
  bit fin = 0;

  // Expected state kept by the bench.
  logic [31:0] e_pc = 0, e_lval = 0, e_msr = 0, e_esr = 0, e_ear = 0, e_btr = 0;
  logic [4:0]  e_lidx = 0;
  bit          m_act = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Winner codes: 0 none, 1 hw break, 2 mmu, 3 hw exc, 4 sw break, 5 irq
  task automatic run_case(input logic [4:0] rq);
    int win;
    bit irq_ok, fatal, acc, lw;
    string ptag, etag;
    logic [31:0] m;
    req_hw_exc = rq[0]; req_mmu = rq[1]; req_irq = rq[2];
    req_sw_brk = rq[3]; req_hw_brk = rq[4]; fault_clear = 1'b0;
    irq_ok = msr_in[1] && !msr_in[9] && !msr_in[3] && !in_dslot;
    if (rq[4])                 win = 1;
    else if (rq[1])            win = 2;
    else if (rq[0] && exc_en)  win = 3;
    else if (rq[3])            win = 4;
    else if (rq[2] && irq_ok)  win = 5;
    else                       win = 0;
    fatal = (win == 2) && m_act;
    acc = (win != 0) && !fatal;
    lw = acc && (win != 4);
    case (win)
      1: ptag = "R8"; 2: ptag = "R3"; 3: ptag = "R2"; 4: ptag = "R8"; 5: ptag = "R7";
      default: ptag = "R9";
    endcase
    if ($countones(rq) > 1) ptag = "R1";
    if (fatal) ptag = "R10";
    etag = (win == 2) ? "R4" : "R5";
    if (acc) begin
      m = msr_in;
      m[14] = msr_in[13]; m[12] = msr_in[11]; m[13] = 1'b0; m[11] = 1'b0;
      e_esr = esr_in; e_ear = ear_in; e_btr = btr_in;
      case (win)
        1: begin e_pc = 32'h18; e_lidx = 5'd16; e_lval = pc_in; m[3] = 1'b1; end
        2: begin
          e_pc = 32'h20; e_lidx = 5'd17; m[9] = 1'b1;
          if (in_dslot) e_lval = pc_in - (br_had_imm ? 32'd8 : 32'd4);
          else          e_lval = pc_in - (imm_pend ? 32'd4 : 32'd0);
          e_esr = 32'd16 + (flt_miss ? 32'd2 : 32'd0) + ((flt_acc == 2'd2) ? 32'd1 : 32'd0);
          if (flt_acc == 2'd1) e_esr = e_esr | 32'h400;
          e_ear = flt_addr;
          m_act = 1;
        end
        3: begin e_pc = 32'h20; e_lidx = 5'd17; e_lval = pc_in + 32'd4; m[9] = 1'b1; end
        4: begin e_pc = btarget_in; m[3] = 1'b1; end
        5: begin e_pc = 32'h10; e_lidx = 5'd14; e_lval = pc_in; m[1] = 1'b0; end
        default: ;
      endcase
      if (win == 2 || win == 3) begin
        e_esr = (e_esr & ~32'h1000) | (in_dslot ? 32'h1000 : 32'h0);
        if (in_dslot) e_btr = btarget_in;
      end
      e_msr = m;
    end
    @(negedge clk);
    chk("R9 done", {31'b0, done}, {31'b0, acc});
    chk("R9 state_clr", {31'b0, state_clr}, {31'b0, acc});
    chk("R10 fatal_err", {31'b0, fatal_err}, {31'b0, fatal});
    chk("R9 link_we", {31'b0, link_we}, {31'b0, lw});
    chk({ptag, " pc_out"}, pc_out, e_pc);
    chk({ptag, " link_idx"}, {27'b0, link_idx}, {27'b0, e_lidx});
    chk({ptag, " link_val"}, link_val, e_lval);
    chk("R6 msr_out", msr_out, e_msr);
    chk({etag, " esr_out"}, esr_out, e_esr);
    chk("R4 ear_out", ear_out, e_ear);
    chk("R5 btr_out", btr_out, e_btr);
  endtask

  task automatic idle_step();
    req_hw_exc = 0; req_mmu = 0; req_irq = 0; req_sw_brk = 0; req_hw_brk = 0;
    fault_clear = 1'b1;
    @(negedge clk);
    m_act = 0;
    chk("R9 idle done", {31'b0, done}, 32'd0);
    chk("R9 idle pc_out", pc_out, e_pc);
  endtask

  task automatic set_ctx(input int s, input int f, input int mb, input int k);
    pc_in      = 32'h0000_4000 + 32'(s) * 32'd16;
    btarget_in = 32'h0008_0000 + 32'(s) * 32'd8;
    flt_addr   = 32'hC000_0000 ^ (32'(s) << 3);
    ear_in     = 32'hEAEA_0000 | 32'(s);
    btr_in     = 32'hB7B7_0000 | 32'(s);
    esr_in     = 32'h0000_F0F3;
    {br_had_imm, imm_pend, in_dslot} = 3'(f);
    msr_in = 32'h5A5A_0024;
    msr_in[13] = mb[0]; msr_in[11] = mb[1]; msr_in[1] = mb[2];
    msr_in[9]  = mb[3]; msr_in[3]  = mb[4];
    flt_miss = k[0];
    flt_acc  = 2'(k >> 1);
  endtask

  initial begin
    #1600000;
    if (!fin) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int s;
    exc_en = 1; fault_clear = 0;
    req_hw_exc = 0; req_mmu = 0; req_irq = 0; req_sw_brk = 0; req_hw_brk = 0;
    set_ctx(0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Reset state (R9)
    chk("R9 reset done", {31'b0, done}, 32'd0);
    chk("R9 reset pc_out", pc_out, 32'd0);
    chk("R10 reset fatal", {31'b0, fatal_err}, 32'd0);
    chk("R9 reset msr_out", msr_out, 32'd0);

    // Sweep every class alone against flags and MSR bits.
    s = 0;
    for (int ev = 0; ev < 5; ev++) begin
      for (int f = 0; f < 8; f++) begin
        for (int mb = 0; mb < 32; mb++) begin
          for (int k = 0; k < ((ev == 1) ? 6 : 1); k++) begin
            s++;
            set_ctx(s, f, mb, k);
            run_case(5'(1 << ev));
            idle_step();
          end
        end
      end
    end

    // R1 priority with mixed requests; interrupt-friendly MSR.
    set_ctx(7, 0, 4, 0);
    run_case(5'b11111); idle_step();
    run_case(5'b01111); idle_step();
    run_case(5'b01101); idle_step();
    run_case(5'b01100); idle_step();
    run_case(5'b00101); idle_step();

    // R2 hardware exception refused while disabled; lower request proceeds.
    exc_en = 0;
    run_case(5'b00001); idle_step();
    run_case(5'b01001); idle_step();
    run_case(5'b00101); idle_step();
    exc_en = 1;

    // R10 recursive MMU fault.
    set_ctx(9, 1, 0, 3);
    run_case(5'b00010);
    set_ctx(10, 0, 0, 2);
    run_case(5'b00010);
    run_case(5'b10000);
    run_case(5'b00010);
    idle_step();
    run_case(5'b00010);
    idle_step();

    fin = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule